// File: doc/BRIEF.md
# Double-and-Add Scalar Multiplication Sequencer

This block is the top-level controller for computing k·P on an elliptic curve over a 261-bit binary field. It does no arithmetic. It accepts a scalar and a start request. It then asks the coordinate store to load the base-point X coordinate and clear the Z accumulator. After that step is acknowledged, it asks for the Y coordinate. Once the second acknowledgement arrives, it walks the scalar from its most significant bit towards bit 0.

For each bit the sequencer issues one point-doubling request to an external doubling unit. It waits for that unit's done pulse. If the examined bit is one, it then issues a point-addition request to an external addition unit and waits for that unit's done pulse. It then shifts the scalar left and moves on to the next bit. The run ends after the last bit, or early when the stop input is high as a bit is retired. At the end the block raises a one-cycle completion pulse and returns to idle.

The arithmetic units answer after arbitrary latencies, so every step waits for its handshake. The only steps that advance on their own are the bit examination, the shift and the finish step.

Top module: `ecc_ladder_ctrl`

## Requirements
- R1: A start_i pulse in idle captures scalar_i. On the next clock edge busy_o rises and ld_xz_o is high for exactly one cycle.
- R2: ld_y_o pulses only after an advance_i acknowledgement of the X/Z load. The first dbl_req_o comes only after a second advance_i that acknowledges the Y load.
- R3: A full run issues exactly KW doubling requests (261 by default). The scalar is consumed most significant bit first.
- R4: An add_req_o pulse follows the doubling done of a bit exactly when that bit is one. The run therefore issues popcount(scalar) additions, each one placed after the doubling of its own bit.
- R5: Every request is a single-cycle pulse. No doubling or addition request is issued while an earlier doubling or addition is still waiting for its done pulse. At most one of ld_xz_o, ld_y_o, dbl_req_o, add_req_o and done_o is high in any cycle.
- R6: After the last bit is retired, done_o is high for one cycle with busy_o low, and the block is back in idle.
- R7: If stop_i is high when bit j (counting from 1 at the MSB) is retired, the run ends after that bit. It then shows j doublings and the additions of the top j bits only, followed by one done_o pulse.
- R8: start_i is ignored while busy_o is high. No new load request is issued, and the running scalar is unchanged.
- R9: rst_n low at a clock edge (synchronous, active low) forces idle. busy_o and all request and done outputs are low in the following cycle.
- R10: dbl_done_i, add_done_i and advance_i pulses that arrive while idle have no effect. busy_o and all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a scalar multiplication (accepted only in idle) |
| stop_i | input | 1 | End the scan after the bit currently being retired |
| scalar_i | input | KW | Scalar k, sampled with the accepted start |
| advance_i | input | 1 | Acknowledge from the coordinate store for a load step |
| dbl_done_i | input | 1 | Completion pulse from the point-doubling unit |
| add_done_i | input | 1 | Completion pulse from the point-addition unit |
| ld_xz_o | output | 1 | Pulse: load X coordinate, clear Z accumulator |
| ld_y_o | output | 1 | Pulse: load Y coordinate |
| dbl_req_o | output | 1 | Pulse: start one point doubling |
| add_req_o | output | 1 | Pulse: start one point addition |
| busy_o | output | 1 | A multiplication is in progress |
| done_o | output | 1 | One-cycle pulse: k·P is complete |

## Verification
The hardest case to reach from the ports is the interplay of the handshakes with the bit order. The add for a given bit must sit between that bit's doubling done and the next doubling request, and this must hold under every pairing of unit latencies. The bench puts stub units with random one-to-four-cycle latencies behind every handshake. It records each doubling as a new observed bit and marks the bit whenever an addition appears before the next doubling, then compares the rebuilt word against the scalar. Early termination is reached by raising stop_i right after the j-th doubling request is seen. The stub latency keeps that bit's retirement strictly later, so the expected truncated result is known exactly.

// File: rtl/ecc_ladder_pkg.sv
// Package: shared types for the double-and-add sequencer.
// Assumes: eight controller states, encoded in three bits.
package ecc_ladder_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_LOAD_XZ  = 3'd1,
        ST_LOAD_Y   = 3'd2,
        ST_EXAM     = 3'd3,
        ST_DBL_WAIT = 3'd4,
        ST_ADD_WAIT = 3'd5,
        ST_SHIFT    = 3'd6,
        ST_FINISH   = 3'd7
    } ladder_state_e;

    // Width of a counter that must hold the values 0 .. n-1.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ecc_scalar_shreg.sv
// Module: scalar shift register.
// Holds the scalar and presents its current MSB. It loads on load_i and
// shifts left by one on shift_i.
// Assumes: KW >= 2; load_i and shift_i are never high together.
module ecc_scalar_shreg #(
    parameter int unsigned KW = 261
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          shift_i,
    input  logic [KW-1:0] scalar_i,
    output logic          msb_o
);

    logic [KW-1:0] sreg_q;

    // Scalar storage: capture on load, move the next bit up on shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load_i) begin
            sreg_q <= scalar_i;
        end else if (shift_i) begin
            sreg_q <= {sreg_q[KW-2:0], 1'b0};
        end
    end

    // Bit under examination.
    assign msb_o = sreg_q[KW-1];

endmodule

// File: rtl/ecc_bit_counter.sv
// Module: retired-bit counter.
// Counts retired scalar bits and flags the last one.
// Assumes: inc_i is high for one cycle per retired bit and never after
// last_o has been used to finish the run.
module ecc_bit_counter #(
    parameter int unsigned KW = 261,
    parameter int unsigned CW = ecc_ladder_pkg::idx_width(KW)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic inc_i,
    output logic last_o
);

    localparam logic [CW-1:0] LAST_IDX = CW'(KW - 1);

    logic [CW-1:0] cnt_q;

    // Bit index: cleared at start, stepped once per retired bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The bit being retired is the least significant one.
    assign last_o = (cnt_q == LAST_IDX);

endmodule

// File: rtl/ecc_ladder_fsm.sv
// Module: eight-state double-and-add controller.
// Each wait state advances on its handshake input. Requests and the
// completion flag are registered single-cycle pulses, issued on the edge
// that enters the matching wait state.
// Assumes: the external units answer every request with exactly one done.
module ecc_ladder_fsm
    import ecc_ladder_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic advance_i,
    input  logic dbl_done_i,
    input  logic add_done_i,
    input  logic cur_bit_i,
    input  logic last_bit_i,
    output logic load_o,
    output logic shift_o,
    output logic ld_xz_o,
    output logic ld_y_o,
    output logic dbl_req_o,
    output logic add_req_o,
    output logic busy_o,
    output logic done_o
);

    ladder_state_e st_q, st_d;
    logic ld_xz_q, ld_y_q, dbl_req_q, add_req_q, done_q;

    // Next-state selection from the current state and handshakes.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (start_i)    st_d = ST_LOAD_XZ;
            ST_LOAD_XZ:  if (advance_i)  st_d = ST_LOAD_Y;
            ST_LOAD_Y:   if (advance_i)  st_d = ST_EXAM;
            ST_EXAM:                     st_d = ST_DBL_WAIT;
            ST_DBL_WAIT: if (dbl_done_i) st_d = cur_bit_i ? ST_ADD_WAIT : ST_SHIFT;
            ST_ADD_WAIT: if (add_done_i) st_d = ST_SHIFT;
            ST_SHIFT:    st_d = (last_bit_i || stop_i) ? ST_FINISH : ST_EXAM;
            ST_FINISH:                   st_d = ST_IDLE;
            default:                     st_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Pulse registers: each rises on the edge that enters its wait state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_xz_q   <= 1'b0;
            ld_y_q    <= 1'b0;
            dbl_req_q <= 1'b0;
            add_req_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            ld_xz_q   <= (st_q == ST_IDLE)     && start_i;
            ld_y_q    <= (st_q == ST_LOAD_XZ)  && advance_i;
            dbl_req_q <= (st_q == ST_EXAM);
            add_req_q <= (st_q == ST_DBL_WAIT) && dbl_done_i && cur_bit_i;
            done_q    <= (st_q == ST_FINISH);
        end
    end

    assign load_o    = (st_q == ST_IDLE) && start_i;
    assign shift_o   = (st_q == ST_SHIFT);
    assign ld_xz_o   = ld_xz_q;
    assign ld_y_o    = ld_y_q;
    assign dbl_req_o = dbl_req_q;
    assign add_req_o = add_req_q;
    assign busy_o    = (st_q != ST_IDLE);
    assign done_o    = done_q;

endmodule

// File: rtl/ecc_ladder_ctrl.sv
// Module: double-and-add scalar multiplication sequencer (top).
// Joins the scalar shift register, the retired-bit counter and the
// controller. Field arithmetic and coordinate storage sit outside and are
// reached only through the request/done and load/advance handshakes.
// Assumes: KW >= 2; synchronous active-low reset.
module ecc_ladder_ctrl #(
    parameter int unsigned KW = 261
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [KW-1:0] scalar_i,
    input  logic          advance_i,
    input  logic          dbl_done_i,
    input  logic          add_done_i,
    output logic          ld_xz_o,
    output logic          ld_y_o,
    output logic          dbl_req_o,
    output logic          add_req_o,
    output logic          busy_o,
    output logic          done_o
);

    localparam int unsigned CW = ecc_ladder_pkg::idx_width(KW);

    logic load_w, shift_w, cur_bit_w, last_bit_w;

    ecc_scalar_shreg #(.KW(KW)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .shift_i  (shift_w),
        .scalar_i (scalar_i),
        .msb_o    (cur_bit_w)
    );

    ecc_bit_counter #(.KW(KW), .CW(CW)) u_bitcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load_w),
        .inc_i   (shift_w),
        .last_o  (last_bit_w)
    );

    ecc_ladder_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .advance_i  (advance_i),
        .dbl_done_i (dbl_done_i),
        .add_done_i (add_done_i),
        .cur_bit_i  (cur_bit_w),
        .last_bit_i (last_bit_w),
        .load_o     (load_w),
        .shift_o    (shift_w),
        .ld_xz_o    (ld_xz_o),
        .ld_y_o     (ld_y_o),
        .dbl_req_o  (dbl_req_o),
        .add_req_o  (add_req_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

endmodule

// File: rtl/ecc_ladder_ctrl_chk.sv
// Module: protocol checker for the sequencer, bound to the top.
// Tracks outstanding unit operations from the port handshakes and checks
// pulse shape, ordering and reset behaviour.
// Assumes: attached through the bind statement at the end of this file.
module ecc_ladder_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic advance_i,
    input logic dbl_done_i,
    input logic add_done_i,
    input logic ld_xz_o,
    input logic ld_y_o,
    input logic dbl_req_o,
    input logic add_req_o,
    input logic busy_o,
    input logic done_o
);

    logic dbl_pend_q, add_pend_q;

    // Outstanding operations: set by a request, cleared by its done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbl_pend_q <= 1'b0;
            add_pend_q <= 1'b0;
        end else begin
            dbl_pend_q <= (dbl_pend_q | dbl_req_o) & ~dbl_done_i;
            add_pend_q <= (add_pend_q | add_req_o) & ~add_done_i;
        end
    end

    p_ldxz_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ld_xz_o |-> busy_o);

    p_ldy_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_y_o |-> $past(advance_i));

    p_add_after_dbl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        add_req_o |-> $past(dbl_done_i));

    p_pulse_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_xz_o, ld_y_o, dbl_req_o, add_req_o, done_o}));

    p_dbl_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_req_o |-> (!dbl_pend_q && !add_pend_q));

    p_add_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        add_req_o |-> (!dbl_pend_q && !add_pend_q));

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !ld_xz_o);

    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !ld_xz_o && !ld_y_o && !dbl_req_o
                    && !add_req_o && !done_o));

endmodule

bind ecc_ladder_ctrl ecc_ladder_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .advance_i  (advance_i),
    .dbl_done_i (dbl_done_i),
    .add_done_i (add_done_i),
    .ld_xz_o    (ld_xz_o),
    .ld_y_o     (ld_y_o),
    .dbl_req_o  (dbl_req_o),
    .add_req_o  (add_req_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/ecc_ladder_ctrl_bench.sv
// Bench: stub doubling/addition/load units with random latencies. Each run
// rebuilds the scalar from the observed request order.
module ecc_ladder_ctrl_bench;

    localparam int KW = 261;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          stop_i = 1'b0;
    logic [KW-1:0] scalar_i = '0;
    logic          advance_i, dbl_done_i, add_done_i;
    logic          ld_xz_o, ld_y_o, dbl_req_o, add_req_o, busy_o, done_o;

    logic spur_dbl = 1'b0, spur_add = 1'b0, spur_adv = 1'b0;
    logic dbl_pulse = 1'b0, add_pulse = 1'b0, adv_pulse = 1'b0;
    int   dbl_wait = 0, add_wait = 0, adv_wait = 0;

    int n_chk = 0, n_fail = 0;
    int n_dbl = 0, n_add = 0, n_done = 0, n_ldxz = 0, n_ldy = 0;
    int seq_err = 0, proto_err = 0;
    bit adv_seen = 0, dbl_out = 0, add_out = 0;
    logic [KW-1:0] obs = '0;

    assign dbl_done_i = dbl_pulse | spur_dbl;
    assign add_done_i = add_pulse | spur_add;
    assign advance_i  = adv_pulse | spur_adv;

    always #2 clk = ~clk;   // 250 MHz

    ecc_ladder_ctrl #(.KW(KW)) u_ecc_ladder_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .scalar_i(scalar_i), .advance_i(advance_i), .dbl_done_i(dbl_done_i),
        .add_done_i(add_done_i), .ld_xz_o(ld_xz_o), .ld_y_o(ld_y_o),
        .dbl_req_o(dbl_req_o), .add_req_o(add_req_o), .busy_o(busy_o),
        .done_o(done_o)
    );

    // Stub units: answer each request after 1..4 cycles with a done pulse.
    always @(negedge clk) begin
        dbl_pulse = 1'b0; add_pulse = 1'b0; adv_pulse = 1'b0;
        if (dbl_wait > 0) begin dbl_wait--; if (dbl_wait == 0) dbl_pulse = 1'b1; end
        if (add_wait > 0) begin add_wait--; if (add_wait == 0) add_pulse = 1'b1; end
        if (adv_wait > 0) begin adv_wait--; if (adv_wait == 0) adv_pulse = 1'b1; end
        if (dbl_req_o) dbl_wait = $urandom_range(4, 1);
        if (add_req_o) add_wait = $urandom_range(4, 1);
        if (ld_xz_o || ld_y_o) adv_wait = $urandom_range(4, 1);
    end

    // Monitor: count requests, rebuild the scalar, flag protocol errors.
    always @(posedge clk) begin
        if ((dbl_req_o || add_req_o) && (dbl_out || add_out)) proto_err++;
        if (ld_y_o && (n_ldxz == 0 || !adv_seen)) seq_err++;
        if (dbl_req_o && n_ldy == 0) seq_err++;
        if (dbl_req_o) begin n_dbl++; obs = {obs[KW-2:0], 1'b0}; end
        if (add_req_o) begin n_add++; obs[0] = 1'b1; end
        if (done_o) n_done++;
        if (ld_xz_o) n_ldxz++;
        if (ld_y_o) n_ldy++;
        if (advance_i && n_ldxz > 0) adv_seen = 1;
        dbl_out = (dbl_out | dbl_req_o) & ~dbl_done_i;
        add_out = (add_out | add_req_o) & ~add_done_i;
    end

    task automatic check(input string tag, input bit ok, input string detail);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, detail);
        end
    endtask

    function automatic int popc(input logic [KW-1:0] v);
        int c = 0;
        for (int i = 0; i < KW; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic logic [KW-1:0] rand_k();
        logic [287:0] t;
        for (int i = 0; i < 9; i++) t[i*32 +: 32] = $urandom();
        return t[KW-1:0];
    endfunction

    task automatic clear_mon();
        n_dbl = 0; n_add = 0; n_done = 0; n_ldxz = 0; n_ldy = 0;
        seq_err = 0; proto_err = 0; adv_seen = 0; dbl_out = 0; add_out = 0;
        obs = '0;
    endtask

    task automatic wait_dbl(input int n);
        for (int g = 0; g < 20000 && n_dbl < n; g++) @(negedge clk);
    endtask

    // One multiplication; stop_at > 0 raises stop_i after that doubling.
    task automatic run_k(input logic [KW-1:0] k, input int stop_at, input bit poke);
        int j;
        logic [KW-1:0] exp_obs;
        @(negedge clk);
        clear_mon();
        scalar_i = k; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R1", ld_xz_o && busy_o,
              $sformatf("ld_xz=%0b busy=%0b expected 1 1", ld_xz_o, busy_o));
        if (poke) begin
            wait_dbl(3);
            scalar_i = ~k; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0; scalar_i = k;
        end
        if (stop_at > 0) begin
            wait_dbl(stop_at);
            stop_i = 1'b1;
        end
        for (int g = 0; g < 20000 && n_done == 0; g++) @(negedge clk);
        stop_i = 1'b0;
        repeat (3) @(negedge clk);
        j = (stop_at > 0) ? stop_at : KW;
        exp_obs = k >> (KW - j);
        check(stop_at > 0 ? "R7" : "R3", n_dbl == j,
              $sformatf("doublings %0d expected %0d", n_dbl, j));
        check("R4", obs == exp_obs,
              $sformatf("bit order %h expected %h", obs, exp_obs));
        check("R4", n_add == popc(exp_obs),
              $sformatf("additions %0d expected %0d", n_add, popc(exp_obs)));
        check("R6", n_done == 1 && !busy_o,
              $sformatf("done pulses %0d busy %0b expected 1 0", n_done, busy_o));
        check("R5", proto_err == 0,
              $sformatf("overlapping requests %0d expected 0", proto_err));
        check("R2", seq_err == 0 && n_ldy == 1,
              $sformatf("load order errors %0d ld_y %0d expected 0 1", seq_err, n_ldy));
        if (poke)
            check("R8", n_ldxz == 1,
                  $sformatf("load X/Z pulses %0d expected 1", n_ldxz));
    endtask

    function automatic bit quiet();
        return !busy_o && !ld_xz_o && !ld_y_o && !dbl_req_o && !add_req_o && !done_o;
    endfunction

    // Global watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [KW-1:0] k;
        repeat (3) @(negedge clk);
        check("R9", quiet(), "outputs not idle during reset, expected all low");
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", quiet(), "outputs not idle after reset, expected all low");

        // R10: stray handshakes while idle are ignored.
        clear_mon();
        @(posedge clk); #1 spur_dbl = 1'b1;
        @(posedge clk); #1 spur_dbl = 1'b0; spur_add = 1'b1;
        @(posedge clk); #1 spur_add = 1'b0; spur_adv = 1'b1;
        @(posedge clk); #1 spur_adv = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", quiet() && n_dbl == 0 && n_add == 0 && n_ldy == 0,
              $sformatf("busy %0b reqs %0d/%0d expected idle, 0/0", busy_o, n_dbl, n_add));

        // R3/R4 pattern sweep: zero, all ones, alternating, single bits.
        run_k('0, 0, 0);
        run_k('1, 0, 0);
        for (int i = 0; i < KW; i++) k[i] = i[0];
        run_k(k, 0, 0);
        run_k(~k, 0, 0);
        run_k({1'b1, {(KW-1){1'b0}}}, 0, 0);
        run_k({{(KW-1){1'b0}}, 1'b1}, 0, 0);
        run_k({{(KW-131){1'b0}}, 1'b1, {130{1'b0}}}, 0, 0);
        for (int r = 0; r < 5; r++) run_k(rand_k(), 0, 0);

        // R7: early stop at several depths.
        run_k(rand_k(), 1, 0);
        run_k(rand_k(), 37, 0);
        run_k('1, 200, 0);

        // R8: start during a run.
        run_k(rand_k(), 0, 1);

        // R9: synchronous reset in the middle of a run.
        @(negedge clk);
        clear_mon();
        scalar_i = '1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_dbl(5);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", quiet(), $sformatf("busy %0b after mid-run reset, expected 0", busy_o));
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R9", quiet(), "block left idle after reset release, expected idle");
        run_k(rand_k(), 0, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule